// File: doc/BRIEF.md
# Hall-Sensor Commutation Decoder

The block turns the three digital phase signals of a brushless motor's Hall sensors into gate enables for a three-leg half-bridge. Each leg is driven to one of three states: sourcing (high-side switch on), sinking (low-side switch on) or floating (both switches off). The decoded six-step pattern depends on a direction select. In reverse, the Hall code is inverted bit by bit before the same pattern is applied.

The high-side switch of the sourcing leg carries the PWM chopping, controlled by a PWM-on qualifier. While that qualifier is low, the low-side switch of the same leg conducts instead, which gives synchronous rectification. A stop select brakes the motor by turning on every low-side switch. A protection-off request floats every leg.

The Hall inputs are synchronised and glitch-filtered before decoding. Every leg enforces a programmable dead time whenever its switches change. The block also gives a one-Hall speed pulse as the pull-down control of an open-drain pin.

Top module: `hall_commut_top`

## Requirements
- R1: With fwd_i=1, run_i=1, prot_off_i=0 and pwm_on_i=1, the filtered Hall code {IN3,IN2,IN1} = hall_i[2:0] selects the source and sink legs as follows, with every other leg floating. Leg bit 0 is OUT1, bit 1 is OUT2 and bit 2 is OUT3.
  - 101: sink OUT1, source OUT2.
  - 001: sink OUT1, source OUT3.
  - 011: sink OUT2, source OUT3.
  - 010: source OUT1, sink OUT2.
  - 110: source OUT1, sink OUT3.
  - 100: source OUT2, sink OUT3.
  - A source leg has hi_en_o=1 and lo_en_o=0. A sink leg has lo_en_o=1 and hi_en_o=0.
- R2: With fwd_i=0, the legs are chosen as R1 gives for the bitwise inverse of the Hall code.
- R3: Hall codes 000 and 111 float all three legs in either direction.
- R4: While pwm_on_i=0 in run mode, the source leg has its high-side switch off and its low-side switch on. The sink leg keeps its low-side switch on.
- R5: With run_i=0, all lo_en_o bits are 1 and all hi_en_o bits are 0, whatever the Hall code, prot_off_i or pwm_on_i. The cycle after run_i is sampled low, hi_en_o is 000.
- R6: With run_i=1 and prot_off_i=1, all six enables are 0, starting the cycle after the request is sampled.
- R7: speed_pd_o equals the filtered IN1 (hall_i[0]). When it is 1 the open-drain pin is pulled low, so the pin level is the inverse of IN1.
- R8: No leg ever has hi_en_o and lo_en_o asserted together.
- R9: After either switch of a leg turns off, neither switch of that leg turns on until both have been off for at least DEAD_CYC clock cycles.
- R10: A change on a Hall input is decoded only once FILT_LEN consecutive synchronised samples agree. A change lasting FILT_LEN-1 cycles has no effect on any output.
- R11: During and right after reset, all enables and speed_pd_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| hall_i | input | 3 | Raw Hall phases; bit 0 is IN1 |
| fwd_i | input | 1 | 1 selects forward, 0 selects reverse |
| run_i | input | 1 | 1 runs the motor, 0 applies the short brake |
| pwm_on_i | input | 1 | 1 during the PWM on-time |
| prot_off_i | input | 1 | 1 floats all legs |
| hi_en_o | output | 3 | High-side gate enables, bit 0 is OUT1 |
| lo_en_o | output | 3 | Low-side gate enables, bit 0 is OUT1 |
| speed_pd_o | output | 1 | Pull-down control of the open-drain speed pin |

## Verification
The bench builds the block with DEAD_CYC=3 and FILT_LEN=3. A short dead time lets PWM toggling and direction changes produce many switch reversals within a few cycles each. Each reversal is measured against the minimum gap by a monitor on the enable ports. A three-sample filter makes the two-cycle glitch (rejected) and the three-cycle pulse (accepted) cheap to drive precisely on the speed output. All sixteen direction-and-code combinations are checked with PWM on and off, then brake, protection-off and recovery.

// File: rtl/hall_commut_pkg.sv
package hall_commut_pkg;
  localparam int unsigned NUM_LEGS = 3;
  localparam int unsigned HALL_W   = 3;
endpackage

// File: rtl/hall_glitch_filter.sv
module hall_glitch_filter #(
  parameter int unsigned WIDTH    = 3,
  parameter int unsigned FILT_LEN = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] raw_i,
  output logic [WIDTH-1:0] clean_o
);
  localparam logic [FILT_LEN-1:0] ALL_ONE = {FILT_LEN{1'b1}};

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [1:0]          sync_q;
    logic [FILT_LEN-1:0] win_q;
    logic                clean_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sync_q  <= '0;
        win_q   <= '0;
        clean_q <= 1'b0;
      end else begin
        sync_q <= {sync_q[0], raw_i[b]};
        win_q  <= {win_q[FILT_LEN-2:0], sync_q[1]};
        if (win_q == ALL_ONE)   clean_q <= 1'b1;
        else if (win_q == '0)   clean_q <= 1'b0;
      end
    end

    assign clean_o[b] = clean_q;
  end
endmodule

// File: rtl/commut_table.sv
module commut_table
  import hall_commut_pkg::*;
(
  input  logic [HALL_W-1:0]   code_i,
  input  logic                fwd_i,
  output logic [NUM_LEGS-1:0] src_o,
  output logic [NUM_LEGS-1:0] snk_o
);
  logic [HALL_W-1:0] eff_code;

  // reverse reuses the forward pattern with inverted code
  assign eff_code = fwd_i ? code_i : ~code_i;

  always_comb begin
    src_o = '0;
    snk_o = '0;
    unique case (eff_code)
      3'b101:  begin src_o = 3'b010; snk_o = 3'b001; end
      3'b001:  begin src_o = 3'b100; snk_o = 3'b001; end
      3'b011:  begin src_o = 3'b100; snk_o = 3'b010; end
      3'b010:  begin src_o = 3'b001; snk_o = 3'b010; end
      3'b110:  begin src_o = 3'b001; snk_o = 3'b100; end
      3'b100:  begin src_o = 3'b010; snk_o = 3'b100; end
      default: begin src_o = '0;     snk_o = '0;     end
    endcase
  end

  always_comb begin
    if (code_i == 3'b000 || code_i == 3'b111) begin
      assert_invalid_float_R3 : assert ((src_o | snk_o) == '0);
    end else if (!$isunknown(code_i) && !$isunknown(fwd_i)) begin
      assert_one_src_one_snk_R1 : assert ($countones(src_o) == 1 &&
                                          $countones(snk_o) == 1 &&
                                          (src_o & snk_o) == '0);
    end
  end
endmodule

// File: rtl/leg_driver.sv
module leg_driver #(
  parameter int unsigned DEAD_CYC = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hi_req_i,
  input  logic lo_req_i,
  output logic hi_o,
  output logic lo_o
);
  localparam int unsigned    CW     = (DEAD_CYC < 2) ? 1 : $clog2(DEAD_CYC + 1);
  localparam logic [CW-1:0] RELOAD = CW'(DEAD_CYC - 1);
  localparam logic [CW-1:0] GAP_MAX = CW'(DEAD_CYC);

  logic          hi_q, lo_q;
  logic [CW-1:0] cnt_q;

  // release first, then hold both off for DEAD_CYC cycles
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q  <= 1'b0;
      lo_q  <= 1'b0;
      cnt_q <= '0;
    end else if (hi_q && !hi_req_i) begin
      hi_q  <= 1'b0;
      cnt_q <= RELOAD;
    end else if (lo_q && !lo_req_i) begin
      lo_q  <= 1'b0;
      cnt_q <= RELOAD;
    end else if (!hi_q && !lo_q) begin
      if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
      else if (hi_req_i) hi_q  <= 1'b1;
      else if (lo_req_i) lo_q  <= 1'b1;
    end
  end

  assign hi_o = hi_q;
  assign lo_o = lo_q;

  // checker: cycles both switches have been off, saturating
  logic [CW-1:0] gap_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                gap_q <= GAP_MAX;
    else if (hi_q || lo_q)      gap_q <= '0;
    else if (gap_q != GAP_MAX)  gap_q <= gap_q + 1'b1;
  end

  assert_no_shoot_through_R8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hi_q && lo_q));

  assert_dead_gap_R9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(hi_q) || $rose(lo_q)) |-> (gap_q >= GAP_MAX));
endmodule

// File: rtl/hall_commut_top.sv
module hall_commut_top
  import hall_commut_pkg::*;
#(
  parameter int unsigned DEAD_CYC = 8,
  parameter int unsigned FILT_LEN = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [HALL_W-1:0]   hall_i,
  input  logic                fwd_i,
  input  logic                run_i,
  input  logic                pwm_on_i,
  input  logic                prot_off_i,
  output logic [NUM_LEGS-1:0] hi_en_o,
  output logic [NUM_LEGS-1:0] lo_en_o,
  output logic                speed_pd_o
);
  logic [HALL_W-1:0]   hall_f;
  logic [NUM_LEGS-1:0] src, snk, hi_req, lo_req;

  hall_glitch_filter #(.WIDTH(HALL_W), .FILT_LEN(FILT_LEN)) u_filt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .raw_i   (hall_i),
    .clean_o (hall_f)
  );

  commut_table u_table (
    .code_i (hall_f),
    .fwd_i  (fwd_i),
    .src_o  (src),
    .snk_o  (snk)
  );

  for (genvar l = 0; l < NUM_LEGS; l++) begin : g_leg
    always_comb begin
      if (!run_i) begin
        hi_req[l] = 1'b0;
        lo_req[l] = 1'b1;
      end else if (prot_off_i) begin
        hi_req[l] = 1'b0;
        lo_req[l] = 1'b0;
      end else begin
        hi_req[l] = src[l] & pwm_on_i;
        lo_req[l] = snk[l] | (src[l] & ~pwm_on_i);
      end
    end

    leg_driver #(.DEAD_CYC(DEAD_CYC)) u_leg (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .hi_req_i (hi_req[l]),
      .lo_req_i (lo_req[l]),
      .hi_o     (hi_en_o[l]),
      .lo_o     (lo_en_o[l])
    );
  end

  assign speed_pd_o = hall_f[0];

  assert_brake_high_off_R5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (hi_en_o == '0));

  assert_prot_all_off_R6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && prot_off_i) |=> (hi_en_o == '0 && lo_en_o == '0));
endmodule

// File: tb/hall_commut_top_tb_top.sv
`timescale 1ns/1ps
module hall_commut_top_tb_top;
  localparam int DEAD = 3;
  localparam int FILT = 3;
  localparam int SETTLE = 24;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] hall = 3'b101;
  logic       fwd = 1'b1, run = 1'b1, pwm = 1'b1, prot = 1'b0;
  logic [2:0] hi_en, lo_en;
  logic       spd;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  hall_commut_top #(.DEAD_CYC(DEAD), .FILT_LEN(FILT)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .hall_i(hall), .fwd_i(fwd), .run_i(run),
    .pwm_on_i(pwm), .prot_off_i(prot), .hi_en_o(hi_en), .lo_en_o(lo_en),
    .speed_pd_o(spd)
  );

  // {fwd, hall[2:0], src[2:0], snk[2:0]}
  localparam logic [9:0] VEC [16] = '{
    {1'b1, 3'b101, 3'b010, 3'b001},
    {1'b1, 3'b001, 3'b100, 3'b001},
    {1'b1, 3'b011, 3'b100, 3'b010},
    {1'b1, 3'b010, 3'b001, 3'b010},
    {1'b1, 3'b110, 3'b001, 3'b100},
    {1'b1, 3'b100, 3'b010, 3'b100},
    {1'b1, 3'b000, 3'b000, 3'b000},
    {1'b1, 3'b111, 3'b000, 3'b000},
    {1'b0, 3'b010, 3'b010, 3'b001},
    {1'b0, 3'b110, 3'b100, 3'b001},
    {1'b0, 3'b100, 3'b100, 3'b010},
    {1'b0, 3'b101, 3'b001, 3'b010},
    {1'b0, 3'b001, 3'b001, 3'b100},
    {1'b0, 3'b011, 3'b010, 3'b100},
    {1'b0, 3'b111, 3'b000, 3'b000},
    {1'b0, 3'b000, 3'b000, 3'b000}
  };

  task automatic chk(input string req, input logic [6:0] act, input logic [6:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act={spd,hi,lo}=%b exp=%b", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // dead-time and shoot-through monitor on the ports (R8, R9)
  int         gap  [3] = '{100, 100, 100};
  logic [2:0] p_hi = '0, p_lo = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      for (int l = 0; l < 3; l++) begin
        if (hi_en[l] && lo_en[l]) begin
          n_checks++; n_fail++;
          $display("FAIL R8 leg%0d act=hi1lo1 exp=not both", l);
        end
        if (hi_en[l] || lo_en[l]) begin
          if (!(p_hi[l] || p_lo[l])) begin
            n_checks++;
            if (gap[l] < DEAD) begin
              n_fail++;
              $display("FAIL R9 leg%0d act gap=%0d exp>=%0d", l, gap[l], DEAD);
            end
          end else if (hi_en[l] != p_hi[l]) begin
            n_checks++; n_fail++;
            $display("FAIL R9 leg%0d act gap=0 exp>=%0d", l, DEAD);
          end
          gap[l] = 0;
        end else if (gap[l] < 100) begin
          gap[l]++;
        end
      end
      p_hi = hi_en;
      p_lo = lo_en;
    end
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      done = 1'b1;
      n_checks++; n_fail++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [2:0] sv_hi, sv_lo, src, snk;
    bit         stable, seen;

    // R11: reset state
    wait_cyc(5);
    chk("R11 in reset", {spd, hi_en, lo_en}, 7'b0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R11 after reset", {spd, hi_en, lo_en}, 7'b0);

    // R1 R2 R3 R4 R7: table walk, PWM on then off
    for (int v = 0; v < 16; v++) begin
      fwd  = VEC[v][9];
      hall = VEC[v][8:6];
      src  = VEC[v][5:3];
      snk  = VEC[v][2:0];
      pwm  = 1'b1;
      wait_cyc(SETTLE);
      chk(fwd ? "R1/R3/R7 fwd pwm on" : "R2/R3/R7 rev pwm on",
          {spd, hi_en, lo_en}, {hall[0], src, snk});
      pwm = 1'b0;
      wait_cyc(SETTLE);
      chk("R4 pwm off sync rect", {spd, hi_en, lo_en}, {hall[0], 3'b000, snk | src});
    end

    // R5: brake overrides protection-off and table
    fwd = 1'b1; hall = 3'b010; pwm = 1'b1;
    wait_cyc(SETTLE);
    run = 1'b0; prot = 1'b1;
    wait_cyc(SETTLE);
    chk("R5 brake", {spd, hi_en, lo_en}, {1'b0, 3'b000, 3'b111});

    // R6: protection-off floats all
    run = 1'b1;
    wait_cyc(SETTLE);
    chk("R6 prot off", {spd, hi_en, lo_en}, {1'b0, 3'b000, 3'b000});
    prot = 1'b0;
    wait_cyc(SETTLE);
    chk("R6 recovery", {spd, hi_en, lo_en}, {1'b0, 3'b001, 3'b010});

    // R10: short glitch ignored, full-length pulse accepted
    hall = 3'b101;
    wait_cyc(SETTLE);
    chk("R10 baseline", {spd, hi_en, lo_en}, {1'b1, 3'b010, 3'b001});
    sv_hi = hi_en; sv_lo = lo_en;
    hall = 3'b100;
    wait_cyc(FILT - 1);
    hall = 3'b101;
    stable = 1'b1;
    for (int i = 0; i < SETTLE; i++) begin
      @(negedge clk);
      if (spd !== 1'b1 || hi_en !== sv_hi || lo_en !== sv_lo) stable = 1'b0;
    end
    chk("R10 short glitch ignored", {6'b0, stable}, 7'd1);
    hall = 3'b100;
    wait_cyc(FILT);
    hall = 3'b101;
    seen = 1'b0;
    for (int i = 0; i < SETTLE; i++) begin
      @(negedge clk);
      if (spd === 1'b0) seen = 1'b1;
    end
    chk("R10 full pulse accepted", {6'b0, seen}, 7'd1);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule